// File: doc/BRIEF.md
# Video Sync Period Meter

This block measures how far apart successive pulses arrive on the horizontal and vertical sync inputs of a display controller. Firmware reads the results as read-only bytes and turns each period into a frequency. The vertical channel counts ticks of a slow timebase between frames. It also carries the live pin level, the detected pulse polarity and an overflow flag. The horizontal channel counts system clocks between lines. When a line is longer than its counter can hold, it reads zero.

Both inputs are synchronized first. Each input's polarity is then found by comparing its high time against its low time. The period is always measured between leading edges of the active pulse. The vertical timebase is a one-cycle enable that comes from dividing the system clock. At the defaults the system clock is 6 MHz, the divider is 48 (a 125 kHz timebase), the vertical count is 13 bits and the horizontal count is 8 bits.

Top module: `vidsync_meter`

## Requirements
- R1: With vertical leading edges P system clocks apart and P a multiple of TICK_DIV, the vertical count reads P/TICK_DIV - 1. The count is 13 bits, zero-extended from V_CNT_W. Count bits 7..0 are in v_lo_o.
- R2: If more than 2**V_CNT_W timebase ticks pass without a new vertical leading edge, counting stops. The overflow flag (v_hi_o bit 5) then reads 1 and the count reads all ones (2**V_CNT_W - 1). This also happens while the input is idle.
- R3: After an overflow, the next frame that completes inside the limit clears the flag and reports its own count.
- R4: The v_hi_o layout is: bit 7 = synchronized live vsync level, bit 6 = polarity (1 = positive), bit 5 = overflow, bits 4..0 = count bits 12..8. Count and flag come from one capture.
- R5: With horizontal leading edges N clocks apart and N <= 2**H_CNT_W, h_period_o reads N - 1.
- R6: When N > 2**H_CNT_W, h_period_o reads 0.
- R7: Polarity is positive when the input was high for fewer cycles than it was low, over the span from one rising edge to the next. Polarity is positive after reset.
- R8: For a negative-polarity input, periods are measured between falling edges, not rising edges.
- R9: After reset v_lo_o and h_period_o are 0 and v_hi_o is 8'h40. The first leading edge only starts a measurement and reports nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (6 MHz at defaults) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync input, asynchronous |
| vsync_i | input | 1 | Vertical sync input, asynchronous |
| v_lo_o | output | 8 | Vertical count bits 7..0 |
| v_hi_o | output | 8 | Level, polarity, overflow, count bits 12..8 |
| h_period_o | output | H_CNT_W | Horizontal period in clocks minus one, 0 on overflow |

## Verification
The bench builds the block with TICK_DIV = 4, V_CNT_W = 6 and H_CNT_W = 5. With these values the vertical limit is 256 clocks and the horizontal limit is 32 clocks. Both overflow boundaries, including the exact last legal period on each channel, can therefore be reached in a few hundred cycles. The small divider still places the timebase phase inside every vertical window, and the short horizontal limit lets an irregular negative-polarity pulse train reveal which edge is being timed.

// File: rtl/vsm_pkg.sv
package vsm_pkg;
  localparam int unsigned VFIELD_W = 13;

  typedef struct packed {
    logic       lvl;
    logic       pos;
    logic       ovf;
    logic [4:0] cnt_hi;
  } vhi_t;
endpackage

// File: rtl/vsm_sync_edge.sv
module vsm_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/vsm_tick_div.sv
module vsm_tick_div #(
  parameter int unsigned DIV = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/vsm_polarity.sv
module vsm_polarity #(
  parameter int unsigned CW = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic rise_i,
  output logic pos_o
);
  localparam logic [CW-1:0] MAXV = '1;

  logic [CW-1:0] hi_q, lo_q;
  logic          seen_q, pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      seen_q <= 1'b0;
      pos_q  <= 1'b1;
    end else if (rise_i) begin
      // judge the span just closed, then count this high cycle
      if (seen_q) pos_q <= (hi_q < lo_q);
      seen_q <= 1'b1;
      hi_q   <= CW'(1);
      lo_q   <= '0;
    end else if (lvl_i) begin
      if (hi_q != MAXV) hi_q <= hi_q + 1'b1;
    end else begin
      if (lo_q != MAXV) lo_q <= lo_q + 1'b1;
    end
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/vsm_period.sv
module vsm_period #(
  parameter int unsigned W        = 8,
  parameter bit          OVF_ZERO = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         lead_i,
  output logic [W-1:0] val_o,
  output logic         ovf_o
);
  localparam logic [W:0] LIM = (W+1)'(1) << W;

  logic [W:0]   cnt_q;
  logic         sat_q, armed_q;
  logic [W-1:0] val_q;
  logic         ovf_q;
  logic [W-1:0] ovf_val;
  logic         live_ovf, edge_ovf, cap_ok;

  generate
    if (OVF_ZERO) begin : g_ovf_zero
      assign ovf_val = '0;
    end else begin : g_ovf_max
      assign ovf_val = '1;
    end
  endgenerate

  assign live_ovf = en_i & ~sat_q & (cnt_q == LIM) & ~lead_i;
  assign edge_ovf = lead_i & armed_q & sat_q;
  assign cap_ok   = lead_i & armed_q & ~sat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      sat_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (lead_i) begin
      cnt_q   <= en_i ? (W+1)'(1) : '0;
      sat_q   <= 1'b0;
      armed_q <= 1'b1;
    end else if (en_i && !sat_q) begin
      if (cnt_q == LIM) sat_q <= 1'b1;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      ovf_q <= 1'b0;
    end else if (live_ovf || edge_ovf) begin
      val_q <= ovf_val;
      ovf_q <= 1'b1;
    end else if (cap_ok) begin
      val_q <= (cnt_q == '0) ? '0 : W'(cnt_q - 1'b1);
      ovf_q <= 1'b0;
    end
  end

  assign val_o = val_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/vidsync_meter.sv
module vidsync_meter
  import vsm_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 48,
  parameter int unsigned V_CNT_W     = 13,
  parameter int unsigned H_CNT_W     = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hsync_i,
  input  logic               vsync_i,
  output logic [7:0]         v_lo_o,
  output logic [7:0]         v_hi_o,
  output logic [H_CNT_W-1:0] h_period_o
);
  localparam int unsigned POL_W = V_CNT_W + $clog2(TICK_DIV) + 1;

  logic v_lvl, v_rise, v_fall, v_pos, v_lead;
  logic h_lvl, h_rise, h_fall, h_pos, h_lead;
  logic tick;
  logic [V_CNT_W-1:0]  v_val;
  logic                v_ovf;
  logic [VFIELD_W-1:0] v_ext;
  vhi_t                v_hi;

  vsm_sync_edge #(.STAGES(SYNC_STAGES)) u_v_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(vsync_i),
    .lvl_o(v_lvl), .rise_o(v_rise), .fall_o(v_fall)
  );

  vsm_sync_edge #(.STAGES(SYNC_STAGES)) u_h_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(hsync_i),
    .lvl_o(h_lvl), .rise_o(h_rise), .fall_o(h_fall)
  );

  vsm_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  vsm_polarity #(.CW(POL_W)) u_v_pol (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(v_lvl), .rise_i(v_rise), .pos_o(v_pos)
  );

  vsm_polarity #(.CW(POL_W)) u_h_pol (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(h_lvl), .rise_i(h_rise), .pos_o(h_pos)
  );

  assign v_lead = v_pos ? v_rise : v_fall;
  assign h_lead = h_pos ? h_rise : h_fall;

  vsm_period #(.W(V_CNT_W), .OVF_ZERO(1'b0)) u_v_per (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tick), .lead_i(v_lead),
    .val_o(v_val), .ovf_o(v_ovf)
  );

  vsm_period #(.W(H_CNT_W), .OVF_ZERO(1'b1)) u_h_per (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(1'b1), .lead_i(h_lead),
    .val_o(h_period_o), .ovf_o()
  );

  assign v_ext = VFIELD_W'(v_val);

  always_comb begin
    v_hi.lvl    = v_lvl;
    v_hi.pos    = v_pos;
    v_hi.ovf    = v_ovf;
    v_hi.cnt_hi = v_ext[12:8];
  end

  assign v_lo_o = v_ext[7:0];
  assign v_hi_o = v_hi;
endmodule

// File: rtl/vidsync_meter_chk.sv
module vidsync_meter_chk #(
  parameter int unsigned V_CNT_W = 13,
  parameter int unsigned H_CNT_W = 8,
  parameter int unsigned STAGES  = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               vsync_i,
  input logic [7:0]         v_lo_o,
  input logic [7:0]         v_hi_o,
  input logic [H_CNT_W-1:0] h_period_o,
  input logic               v_lead,
  input logic               v_rise,
  input logic               h_lead
);
  localparam logic [12:0] VMAX = 13'((1 << V_CNT_W) - 1);

  logic [3:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != '1)  cyc_q <= cyc_q + 1'b1;
  end

  AST_V_OVF_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_hi_o[5] |-> ({v_hi_o[4:0], v_lo_o} == VMAX)); // R2

  AST_V_CLR_AT_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(v_hi_o[5]) |-> $past(v_lead)); // R3

  AST_V_CNT_AT_LEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({v_hi_o[4:0], v_lo_o}) |-> ($past(v_lead) || v_hi_o[5])); // R1

  AST_V_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q > 4'(STAGES)) |-> (v_hi_o[7] == $past(vsync_i, STAGES))); // R4

  AST_POL_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(v_hi_o[6]) |-> $past(v_rise)); // R7

  AST_H_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(h_period_o) |-> ($past(h_lead) || (h_period_o == '0))); // R5
endmodule

bind vidsync_meter vidsync_meter_chk #(
  .V_CNT_W(V_CNT_W), .H_CNT_W(H_CNT_W), .STAGES(SYNC_STAGES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vsync_i(vsync_i),
  .v_lo_o(v_lo_o), .v_hi_o(v_hi_o), .h_period_o(h_period_o),
  .v_lead(v_lead), .v_rise(v_rise), .h_lead(h_lead)
);

// File: tb/vidsync_meter_tb.sv
module vidsync_meter_tb;
  localparam int unsigned DIV = 4;
  localparam int unsigned VW  = 6;
  localparam int unsigned HW  = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hs = 1'b0;
  logic          vs = 1'b0;
  logic [7:0]    v_lo, v_hi;
  logic [HW-1:0] h_per;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  vidsync_meter #(.TICK_DIV(DIV), .V_CNT_W(VW), .H_CNT_W(HW), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs),
    .v_lo_o(v_lo), .v_hi_o(v_hi), .h_period_o(h_per)
  );

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input bit is_v, input bit lvl);
    if (is_v) vs = lvl; else hs = lvl;
  endtask

  task automatic seg(input bit is_v, input bit lvl, input int cyc);
    set_pin(is_v, lvl);
    wait_n(cyc);
  endtask

  // n pulses with leading edges 'period' apart; ends 4 cycles after the last pulse
  task automatic train(input bit is_v, input bit act_hi, input int period,
                       input int width, input int n);
    seg(is_v, !act_hi, period - width);
    for (int i = 0; i < n; i++) begin
      seg(is_v, act_hi, width);
      if (i < n - 1) seg(is_v, !act_hi, period - width);
      else           seg(is_v, !act_hi, 4);
    end
  endtask

  task automatic t_reset();
    wait_n(3);
    check("R9 v_lo reset", v_lo, 0);
    check("R9 v_hi reset", v_hi, 8'h40);
    check("R9 h reset", h_per, 0);
  endtask

  task automatic t_first_edge();
    train(1'b1, 1'b1, 100, 8, 1);
    check("R9 first vertical edge reports nothing", v_lo, 0);
    check("R9 first vertical edge v_hi", v_hi, 8'h40);
  endtask

  task automatic t_v_period();
    train(1'b1, 1'b1, 100, 8, 3);
    check("R1 v_lo period 100", v_lo, 100 / DIV - 1);
    check("R4 v_hi period 100", v_hi, 8'h40);
    train(1'b1, 1'b1, 256, 8, 3);
    check("R1 v_lo at limit", v_lo, 256 / DIV - 1);
    check("R2 no flag at limit", v_hi, 8'h40);
  endtask

  task automatic t_v_ovf();
    train(1'b1, 1'b1, 260, 8, 3);
    check("R2 v_lo over limit", v_lo, 8'h3F);
    check("R2 v_hi over limit", v_hi, 8'h60);
    train(1'b1, 1'b1, 100, 8, 2);
    check("R3 v_lo after recovery", v_lo, 24);
    check("R3 flag cleared", v_hi, 8'h40);
    wait_n(400);
    check("R2 idle overflow flag", v_hi, 8'h60);
    check("R2 idle overflow count", v_lo, 8'h3F);
  endtask

  task automatic t_v_level_pol();
    seg(1'b1, 1'b1, 6);
    check("R4 live level bit", int'(v_hi[7]), 1);
    seg(1'b1, 1'b0, 6);
    check("R4 live level low", int'(v_hi[7]), 0);
    train(1'b1, 1'b0, 100, 8, 4);
    check("R7 negative vertical v_hi", v_hi, 8'h80);
    check("R8 negative vertical v_lo", v_lo, 24);
    train(1'b1, 1'b1, 120, 8, 4);
    check("R7 back to positive v_hi", v_hi, 8'h40);
    check("R1 v_lo period 120", v_lo, 29);
  endtask

  task automatic t_h_period();
    train(1'b0, 1'b1, 20, 4, 3);
    check("R5 h period 20", h_per, 19);
    train(1'b0, 1'b1, 32, 4, 3);
    check("R5 h at limit", h_per, 31);
    train(1'b0, 1'b1, 33, 4, 3);
    check("R6 h over limit", h_per, 0);
    train(1'b0, 1'b1, 25, 4, 2);
    check("R5 h recovers", h_per, 24);
  endtask

  task automatic t_h_neg_edge();
    train(1'b0, 1'b0, 20, 4, 3);
    check("R8 h negative regular", h_per, 19);
    // falling edges 30 apart, rising edges 34 then 26 apart
    seg(1'b0, 1'b1, 16);
    seg(1'b0, 1'b0, 3);
    seg(1'b0, 1'b1, 27);
    seg(1'b0, 1'b0, 7);
    seg(1'b0, 1'b1, 23);
    seg(1'b0, 1'b0, 3);
    seg(1'b0, 1'b1, 4);
    check("R8 h timed from falling edges", h_per, 29);
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    t_reset();
    t_first_edge();
    t_v_period();
    t_v_ovf();
    t_v_level_pol();
    t_h_period();
    t_h_neg_edge();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule